// File: doc/BRIEF.md
# Self-Timed Byte-Write Nonvolatile Memory Model

This block is a synthesizable, clocked model of a small parallel-bus nonvolatile byte memory. Three active-low strobes control it: chip select, output enable and write enable. All of them are sampled on the system clock. A read behaves like a static RAM. The addressed byte appears on `rd_data` with `rd_drive` high while chip select and output enable are low and write enable is high. When not driving, the data bus is held at zero.

A write is started by a low pulse on either write enable or chip select, with the other strobe held low and output enable high. The address is taken when the combined strobe goes active, which is the falling edge of whichever strobe falls last. The data is taken when the combined strobe ends, which is the rising edge of whichever strobe rises first. After that, an internal timer runs for a fixed number of cycles. During that time the target byte is first set to all ones and then loaded with the new value. A read during that time returns a polling status: the inverted top bit of the byte being written, with zeros on the other bits.

Writes are refused in three cases:
- output enable is low;
- the elevated-voltage flag on output enable is set;
- the supply-good input is low, or a lockout period after it rose has not yet run out.

Holding the strobes low with the elevated-voltage flag on output enable for a set number of cycles fills the whole main array with ones. A second flag, standing in for an elevated voltage on address bit 9, maps the top 32 addresses onto a separate identification area.

Top module: `nvbyte_emu`

## Requirements
- R1: `rd_drive` is 1 exactly when `cs_n`=0, `oe_n`=0 and `we_n`=1. Otherwise `rd_drive`=0 and `rd_data`=0.
- R2: A write starts when the combined strobe (`cs_n`=0 and `we_n`=0) becomes active, with `oe_n`=1. The address comes from the cycle the strobe becomes active, and the data from the cycle it ends. Either strobe may be the one that pulses.
- R3: `wr_busy` is high for exactly `WRITE_CYC` clock cycles, starting in the cycle after the strobe ends. Strobe activity during that time starts no write and changes no byte.
- R4: While `wr_busy`=1, a read returns the inverted bit 7 of the byte being written on bit 7 and zeros on bits 6..0. Once `wr_busy` falls, reads return the stored value.
- R5: No write starts, and no byte changes, if `oe_n`=0 or `hv_oe`=1 while the strobe is active.
- R6: No write starts while `pwr_good`=0, or before `LOCK_CYC` cycles have passed with `pwr_good`=1.
- R7: With `cs_n`=0, `we_n`=0 and `hv_oe`=1 held for `CLEAR_CYC` consecutive cycles, every main-array byte becomes 0xFF. A shorter hold changes nothing.
- R8: With `hv_a9`=1, addresses 0x7E0..0x7FF (address bits 10..5 all ones, index = bits 4..0) read and write a separate 32-byte identification area. The main-array bytes at those addresses, and chip clear, leave that area untouched.
- R9: During and straight after reset, `rd_drive`=0, `rd_data`=0 and `wr_busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| hv_oe | input | 1 | Elevated-voltage flag on output enable (chip clear) |
| hv_a9 | input | 1 | Elevated-voltage flag on address bit 9 (identification area) |
| pwr_good | input | 1 | Supply-good indication |
| addr | input | ADDR_W | Byte address |
| wr_data | input | DATA_W | Write data bus |
| rd_data | output | DATA_W | Read data, zero when not driven |
| rd_drive | output | 1 | Read data is valid and driven |
| wr_busy | output | 1 | Self-timed write in progress |

## Verification
The bench moves the address and data away from their capture cycles on every write. A design that latched the address on the first strobe edge, or the data on the last one, would therefore store the wrong value at the wrong place. Every write, driven by either strobe, is polled during its busy window and timed exactly. An off-by-one timer, or a poll that leaked true data, would be caught. Strobe pulses are issued during a busy write, during the power lockout, with output enable low, and with a clear pulse one cycle short. Each of these must leave the memory unchanged. The final clear must wipe the main array but not the identification bytes, which catches an alias between the two stores.

// File: rtl/nvbyte_pkg.sv
package nvbyte_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ARMED = 2'd1,
      SEQ_BUSY  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/nvbyte_lockout.sv
module nvbyte_lockout #(
   parameter int LOCK_CYC = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   output logic wr_allowed
);
   localparam int CW = $clog2(LOCK_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !pwr_good) cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign wr_allowed = pwr_good && (cnt_q == LIMIT);
endmodule

// File: rtl/nvbyte_clear.sv
module nvbyte_clear #(
   parameter int CLEAR_CYC = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic we_n,
   input  logic hv_oe,
   input  logic allow,
   output logic clr_fire
);
   localparam int CW = $clog2(CLEAR_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(CLEAR_CYC);

   logic          hold;
   logic [CW-1:0] cnt_q;

   assign hold = !cs_n && !we_n && hv_oe && allow;

   always_ff @(posedge clk) begin
      if (!rst_n || !hold) cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   assign clr_fire = hold && (cnt_q == LIMIT - 1'b1);
endmodule

// File: rtl/nvbyte_wrseq.sv
module nvbyte_wrseq
   import nvbyte_pkg::*;
#(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 8,
   parameter int ID_W      = 5,
   parameter int WRITE_CYC = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              hv_oe,
   input  logic              hv_a9,
   input  logic              allow,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              tgt_id,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic [DATA_W-1:0] tgt_data,
   output logic              pre_erase,
   output logic              commit
);
   localparam int TW = $clog2(WRITE_CYC + 1);
   localparam logic [TW-1:0] LAST = TW'(WRITE_CYC - 1);

   seq_state_e    st_q;
   logic          strobe, strobe_q, fall_edge, rise_edge, ok;
   logic [TW-1:0] tmr_q;

   assign strobe    = !cs_n && !we_n;
   assign fall_edge = strobe && !strobe_q;
   assign rise_edge = !strobe && strobe_q;
   assign ok        = allow && oe_n && !hv_oe;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= SEQ_IDLE;
         strobe_q <= 1'b0;
         tmr_q    <= '0;
         tgt_id   <= 1'b0;
         tgt_addr <= '0;
         tgt_data <= '0;
      end else begin
         strobe_q <= strobe;
         unique case (st_q)
            SEQ_IDLE: begin
               if (fall_edge && ok) begin
                  st_q     <= SEQ_ARMED;
                  tgt_addr <= addr;
                  tgt_id   <= hv_a9 && (&addr[ADDR_W-1:ID_W]);
               end
            end
            SEQ_ARMED: begin
               if (!ok) st_q <= SEQ_IDLE;
               else if (rise_edge) begin
                  st_q     <= SEQ_BUSY;
                  tgt_data <= wr_data;
                  tmr_q    <= '0;
               end
            end
            SEQ_BUSY: begin
               tmr_q <= tmr_q + 1'b1;
               if (tmr_q == LAST) st_q <= SEQ_IDLE;
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy      = (st_q == SEQ_BUSY);
   assign pre_erase = busy && (tmr_q == '0);
   assign commit    = busy && (tmr_q == LAST);
endmodule

// File: rtl/nvbyte_emu.sv
module nvbyte_emu #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 8,
   parameter int ID_BYTES  = 32,
   parameter int WRITE_CYC = 10000,
   parameter int LOCK_CYC  = 250000,
   parameter int CLEAR_CYC = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              hv_oe,
   input  logic              hv_a9,
   input  logic              pwr_good,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_drive,
   output logic              wr_busy
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int ID_W  = $clog2(ID_BYTES);
   localparam logic [DATA_W-1:0] ALL1 = '1;

   generate
      if (ADDR_W <= ID_W) begin : g_bad_addr
         $error("ADDR_W must exceed the identification index width");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (ID_BYTES != (1 << ID_W)) begin : g_bad_id
         $error("ID_BYTES must be a power of two");
      end
      if (WRITE_CYC < 2 || LOCK_CYC < 1 || CLEAR_CYC < 2) begin : g_bad_time
         $error("timer lengths out of range");
      end
   endgenerate

   logic                wr_allowed, clr_fire, pre_erase, commit, tgt_id, id_sel;
   logic [ADDR_W-1:0]   tgt_addr;
   logic [DATA_W-1:0]   tgt_data, rd_word;
   logic [DATA_W-1:0]   main_mem [DEPTH];
   logic [DATA_W-1:0]   id_mem   [ID_BYTES];

   nvbyte_lockout #(.LOCK_CYC(LOCK_CYC)) lock_i (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .wr_allowed(wr_allowed)
   );

   nvbyte_wrseq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .WRITE_CYC(WRITE_CYC)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .hv_oe(hv_oe), .hv_a9(hv_a9), .allow(wr_allowed), .addr(addr),
      .wr_data(wr_data), .busy(wr_busy), .tgt_id(tgt_id), .tgt_addr(tgt_addr),
      .tgt_data(tgt_data), .pre_erase(pre_erase), .commit(commit)
   );

   nvbyte_clear #(.CLEAR_CYC(CLEAR_CYC)) clr_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .hv_oe(hv_oe),
      .allow(wr_allowed && !wr_busy), .clr_fire(clr_fire)
   );

   // Cell storage keeps its contents across reset.
   always_ff @(posedge clk) begin
      if (clr_fire) begin
         for (int i = 0; i < DEPTH; i++) main_mem[i] <= ALL1;
      end else if (commit || pre_erase) begin
         if (tgt_id) id_mem[tgt_addr[ID_W-1:0]] <= commit ? tgt_data : ALL1;
         else        main_mem[tgt_addr]         <= commit ? tgt_data : ALL1;
      end
   end

   assign id_sel   = hv_a9 && (&addr[ADDR_W-1:ID_W]);
   assign rd_word  = id_sel ? id_mem[addr[ID_W-1:0]] : main_mem[addr];
   assign rd_drive = !cs_n && !oe_n && we_n;

   always_comb begin
      if (!rd_drive)    rd_data = '0;
      else if (wr_busy) rd_data = {~tgt_data[DATA_W-1], {(DATA_W-1){1'b0}}};
      else              rd_data = rd_word;
   end
endmodule

// File: rtl/nvbyte_emu_chk.sv
module nvbyte_emu_chk #(
   parameter int DATA_W    = 8,
   parameter int WRITE_CYC = 10000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              oe_n,
   input logic              we_n,
   input logic              hv_oe,
   input logic              pwr_good,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_drive,
   input logic              wr_busy
);
   int unsigned busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n || !wr_busy) busy_run <= 0;
      else                    busy_run <= busy_run + 1;
   end

   AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || oe_n || !we_n) |-> (!rd_drive && rd_data == '0)); // R1

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_busy) |-> (busy_run == WRITE_CYC)); // R3

   AST_POLL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_busy && rd_drive) |-> (rd_data[DATA_W-2:0] == '0)); // R4

   AST_START_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy) |-> ($past(oe_n) && !$past(hv_oe))); // R5

   AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_busy) |-> $past(pwr_good)); // R6
endmodule

bind nvbyte_emu nvbyte_emu_chk #(.DATA_W(DATA_W), .WRITE_CYC(WRITE_CYC)) chk_i (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
   .hv_oe(hv_oe), .pwr_good(pwr_good), .rd_data(rd_data),
   .rd_drive(rd_drive), .wr_busy(wr_busy)
);

// File: tb/nvbyte_emu_tb_top.sv
`timescale 1ns/1ps
module nvbyte_emu_tb_top;
   localparam int AW = 11;
   localparam int DW = 8;
   localparam int WC = 6;
   localparam int LC = 12;
   localparam int CC = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic          hv_oe = 1'b0, hv_a9 = 1'b0, pwr_good = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          rd_drive, wr_busy;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   nvbyte_emu #(
      .ADDR_W(AW), .DATA_W(DW), .ID_BYTES(32),
      .WRITE_CYC(WC), .LOCK_CYC(LC), .CLEAR_CYC(CC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .hv_oe(hv_oe), .hv_a9(hv_a9), .pwr_good(pwr_good), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive), .wr_busy(wr_busy)
   );

   function automatic logic [DW-1:0] pat(input int a);
      return DW'((a * 37 + 5) ^ (a >> 3));
   endfunction

   function automatic logic [DW-1:0] idpat(input int i);
      return DW'(i * 3 + 8'h40);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // ce_mode=0: write enable pulses; ce_mode=1: chip select pulses.
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit ce_mode, input bit poll, input bit oe_low,
                           output int n);
      @(negedge clk);
      oe_n = oe_low ? 1'b0 : 1'b1;
      addr = ~a; wr_data = ~d;
      if (ce_mode) begin we_n = 1'b0; cs_n = 1'b1; end
      else         begin cs_n = 1'b0; we_n = 1'b1; end
      @(negedge clk);
      addr = a;
      if (ce_mode) cs_n = 1'b0; else we_n = 1'b0;
      @(negedge clk);
      addr = ~a; wr_data = d;
      @(negedge clk);
      if (ce_mode) cs_n = 1'b1; else we_n = 1'b1;
      n = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         wr_data = ~d;
         if (!wr_busy) break;
         n++;
         if (poll) begin
            cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
            #2;
            chk(rd_drive && rd_data == {~d[DW-1], 7'b0}, "R4 poll",
                rd_data, {~d[DW-1], 7'b0});
            oe_n = 1'b1;
         end
      end
      cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                          output logic en);
      @(negedge clk);
      cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
      #2;
      d = rd_data; en = rd_drive;
      cs_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic do_clear(input int k, output bit saw_busy);
      saw_busy = 1'b0;
      @(negedge clk);
      cs_n = 1'b0; oe_n = 1'b1; hv_oe = 1'b1; we_n = 1'b0;
      for (int j = 0; j < k; j++) begin
         @(negedge clk);
         if (wr_busy) saw_busy = 1'b1;
      end
      we_n = 1'b1; hv_oe = 1'b0; cs_n = 1'b1;
      repeat (3) begin
         @(negedge clk);
         if (wr_busy) saw_busy = 1'b1;
      end
   endtask

   initial begin : watchdog
      #(20ns * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [DW-1:0] d;
      logic en;
      int n;
      bit sb;
      bit ok;

      // R9: reset state
      repeat (3) @(negedge clk);
      chk(!rd_drive && rd_data == 0 && !wr_busy, "R9 in reset", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!rd_drive && rd_data == 0 && !wr_busy, "R9 after reset", {rd_drive, wr_busy}, 0);
      repeat (LC + 2) @(negedge clk);

      // R7: full clear, then every main byte reads 0xFF
      do_clear(CC, sb);
      chk(!sb, "R5 clear pulse starts no write", sb, 0);
      ok = 1'b1;
      for (int a = 0; a < (1 << AW); a++) begin
         do_read(AW'(a), d, en);
         if (!en || d != 8'hFF) begin ok = 1'b0; chk(0, "R7 clear", d, 8'hFF); end
      end
      chk(ok, "R7 clear sweep", ok, 1);

      // R1: bus quiet with output enable high / write enable low
      @(negedge clk);
      cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; #2;
      chk(!rd_drive && rd_data == 0, "R1 oe high", rd_data, 0);
      oe_n = 1'b0; cs_n = 1'b1; #2;
      chk(!rd_drive && rd_data == 0, "R1 cs high", rd_data, 0);
      cs_n = 1'b1; oe_n = 1'b1;

      // R6: supply low, then inside lockout
      @(negedge clk); pwr_good = 1'b0;
      do_write(11'd3, 8'h11, 1'b0, 1'b0, 1'b0, n);
      chk(n == 0, "R6 supply low no start", n, 0);
      do_read(11'd3, d, en);
      chk(d == 8'hFF, "R6 supply low unchanged", d, 8'hFF);
      @(negedge clk); pwr_good = 1'b1;
      do_write(11'd3, 8'h11, 1'b1, 1'b0, 1'b0, n);
      chk(n == 0, "R6 lockout no start", n, 0);
      do_read(11'd3, d, en);
      chk(d == 8'hFF, "R6 lockout unchanged", d, 8'hFF);
      repeat (LC + 2) @(negedge clk);
      do_write(11'd3, 8'h11, 1'b0, 1'b0, 1'b0, n);
      chk(n == WC, "R6 after lockout busy length", n, WC);
      do_read(11'd3, d, en);
      chk(d == 8'h11, "R6 after lockout data", d, 8'h11);

      // R5: output enable low, elevated output-enable flag, short clear
      do_write(11'd4, 8'h22, 1'b0, 1'b0, 1'b1, n);
      chk(n == 0, "R5 oe low no start", n, 0);
      do_read(11'd4, d, en);
      chk(d == 8'hFF, "R5 oe low unchanged", d, 8'hFF);
      do_clear(CC - 1, sb);
      chk(!sb, "R5 hv_oe no write", sb, 0);
      do_read(11'd3, d, en);
      chk(d == 8'h11, "R7 short clear no effect", d, 8'h11);

      // R2 R3 R4: sweep all addresses, both strobe modes, polled
      ok = 1'b1;
      for (int a = 0; a < (1 << AW); a++) begin
         do_write(AW'(a), pat(a), a[0], 1'b1, 1'b0, n);
         if (n != WC) begin ok = 1'b0; chk(0, "R3 busy length", n, WC); end
         do_read(AW'(a), d, en);
         if (!en || d != pat(a)) begin ok = 1'b0; chk(0, "R4 true data after busy", d, pat(a)); end
      end
      chk(ok, "R3 R4 write sweep", ok, 1);
      ok = 1'b1;
      for (int a = 0; a < (1 << AW); a++) begin
         do_read(AW'(a), d, en);
         if (d != pat(a)) begin ok = 1'b0; chk(0, "R2 address/data capture", d, pat(a)); end
      end
      chk(ok, "R2 readback sweep", ok, 1);

      // R3: strobe during busy is ignored
      @(negedge clk);
      cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = 11'd10; wr_data = 8'h5A;
      @(negedge clk); we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk);
      chk(wr_busy, "R3 busy after strobe end", wr_busy, 1);
      addr = 11'd11; wr_data = 8'h00; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
      repeat (WC + 4) @(negedge clk);
      chk(!wr_busy, "R3 no restart", wr_busy, 0);
      do_read(11'd10, d, en);
      chk(d == 8'h5A, "R3 first write lands", d, 8'h5A);
      do_read(11'd11, d, en);
      chk(d == pat(11), "R3 busy strobe ignored", d, pat(11));

      // R8: identification area
      hv_a9 = 1'b1;
      for (int i = 0; i < 32; i++) begin
         do_write(AW'(11'h7E0 + i), idpat(i), i[1], 1'b0, 1'b0, n);
      end
      ok = 1'b1;
      for (int i = 0; i < 32; i++) begin
         do_read(AW'(11'h7E0 + i), d, en);
         if (d != idpat(i)) begin ok = 1'b0; chk(0, "R8 id read", d, idpat(i)); end
      end
      chk(ok, "R8 id sweep", ok, 1);
      hv_a9 = 1'b0;
      ok = 1'b1;
      for (int i = 0; i < 32; i++) begin
         do_read(AW'(11'h7E0 + i), d, en);
         if (d != pat(11'h7E0 + i)) begin ok = 1'b0; chk(0, "R8 main untouched", d, pat(11'h7E0 + i)); end
      end
      chk(ok, "R8 main alias sweep", ok, 1);

      // R7 R8: clear wipes main array but not identification area
      do_clear(CC, sb);
      do_read(11'd100, d, en);
      chk(d == 8'hFF, "R7 clear after writes", d, 8'hFF);
      do_read(11'h7E5, d, en);
      chk(d == 8'hFF, "R7 clear top main", d, 8'hFF);
      hv_a9 = 1'b1;
      do_read(11'h7E5, d, en);
      chk(d == idpat(5), "R8 id survives clear", d, idpat(5));
      hv_a9 = 1'b0;

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule